// File: doc/BRIEF.md
# UART Receiver with Multiprocessor Address Filtering

An asynchronous serial receiver for one node on a shared multidrop line. The serial input is resynchronised and sampled on a tick that runs at `OVS` times the bit rate. Each frame is a start bit, eight or nine data bits sent least significant first, and a stop bit. The received byte and, in nine-bit mode, the ninth bit go into a one-entry buffer. A ready flag signals that the buffer holds a frame, and a read strobe empties it.

For multiprocessor links the receiver can filter by address. In nine-bit mode with the filter on, a frame whose ninth bit is 1 is an address and is delivered. A frame whose ninth bit is 0 is data and is discarded: it is never buffered and never flagged. A node typically keeps the filter on until it sees its own address, then turns the filter off to take the data that follows. In eight-bit mode the filter has no effect.

A framing error is stored with each delivered frame. An overrun flag records a delivery that arrived while the buffer was still unread. Dropping the receive enable clears both error flags.

Top module: `uart_addr_rx`

## Requirements
- R1: A start is detected on the first tick that sees the line low after a tick that saw it high; that tick is sample 1. If the line is high again at sample 8, the receiver returns to idle and delivers nothing.
- R2: Each data bit is the majority of the line at samples 7, 8 and 9 of its 16-sample window. Bits arrive LSB first, so the first data bit lands in `rx_byte[0]`.
- R3: With `mode9`=0, every frame of 8 data bits is delivered, `addr_det` has no effect, and `rx_bit9` reads 0.
- R4: With `mode9`=1, nine data bits are received, and the ninth appears on `rx_bit9` next to `rx_byte`.
- R5: With `mode9`=1 and `addr_det`=1, a frame whose ninth bit is 1 is delivered and sets `ready`. A frame whose ninth bit is 0 leaves `ready`, `rx_byte` and `rx_bit9` unchanged.
- R6: If the majority vote of the stop bit is 0, the frame is still delivered and `frame_err` is set with it. A frame with a good stop bit loads `frame_err` as 0.
- R7: If a frame is delivered while `ready`=1 and no read is strobed, `overrun` is set and the buffer keeps its older contents.
- R8: A one-cycle `rd_strobe` clears `ready`.
- R9: While `rx_en`=0 the line is ignored, and `overrun` and `frame_err` are cleared.
- R10: `mode9` and `addr_det` are captured at start detection. A change during a frame only affects later frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_en | input | 1 | Receive enable |
| mode9 | input | 1 | 1 selects nine data bits |
| addr_det | input | 1 | Address filter enable (nine-bit mode only) |
| tick | input | 1 | One-cycle pulse at OVS times the bit rate |
| rx_in | input | 1 | Serial line, idle high |
| rd_strobe | input | 1 | Consumes the buffered frame |
| rx_byte | output | DW | Buffered data byte |
| rx_bit9 | output | 1 | Buffered ninth bit |
| ready | output | 1 | Buffer holds an unread frame |
| frame_err | output | 1 | Stop bit of buffered frame was 0 |
| overrun | output | 1 | A frame arrived while the buffer was full |

## Verification
The bench builds the receiver with `OVS`=16 and `DW`=8, and pulses `tick` once every four clocks. Every line change is aligned to a tick, so the bench can place a glitch on any single sample of any bit. This lets it hit the mid-bit start check and the 7/8/9 vote window precisely. Nine-bit frames make the address filter and the mid-frame mode-change cases reachable.

// File: rtl/uart_addr_rx.sv
module uart_addr_rx #(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_en,
  input  logic          mode9,
  input  logic          addr_det,
  input  logic          tick,
  input  logic          rx_in,
  input  logic          rd_strobe,
  output logic [DW-1:0] rx_byte,
  output logic          rx_bit9,
  output logic          ready,
  output logic          frame_err,
  output logic          overrun
);
  localparam int CW  = $clog2(OVS + 1);
  localparam int IW  = $clog2(DW + 1);
  localparam int MID = OVS / 2;

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} st_t;

  st_t           st;
  logic [1:0]    sync;
  logic [CW-1:0] cnt;
  logic [IW-1:0] idx;
  logic [DW:0]   shreg;
  logic          v1, v2, prev, m9_l, ad_l;

  wire rx_s     = sync[1];
  wire vote     = (v1 & v2) | (v1 & rx_s) | (v2 & rx_s);
  wire last_bit = idx == (m9_l ? IW'(DW) : IW'(DW - 1));
  wire keep     = !(m9_l && ad_l && !shreg[DW]);
  wire at_stop  = tick && st == S_STOP && cnt == CW'(MID + 1);
  wire load     = rx_en && at_stop && keep;
  wire take     = load && (!ready || rd_strobe);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], rx_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cnt   <= '0;
      idx   <= '0;
      shreg <= '0;
      v1    <= 1'b1;
      v2    <= 1'b1;
      prev  <= 1'b1;
      m9_l  <= 1'b0;
      ad_l  <= 1'b0;
    end else if (!rx_en) begin
      st   <= S_IDLE;
      prev <= 1'b1;
    end else if (tick) begin
      prev <= rx_s;
      cnt  <= (cnt == CW'(OVS)) ? CW'(1) : cnt + CW'(1);
      if (st != S_IDLE) begin
        if (cnt == CW'(MID - 1)) v1 <= rx_s;
        if (cnt == CW'(MID))     v2 <= rx_s;
      end
      case (st)
        S_IDLE:
          if (prev && !rx_s) begin
            st   <= S_START;
            cnt  <= CW'(2);
            m9_l <= mode9;
            ad_l <= addr_det;
          end
        S_START:
          if (cnt == CW'(MID) && rx_s) st <= S_IDLE;
          else if (cnt == CW'(OVS)) begin
            st  <= S_DATA;
            idx <= '0;
          end
        S_DATA: begin
          if (cnt == CW'(MID + 1)) shreg[idx] <= vote;
          if (cnt == CW'(OVS)) begin
            if (last_bit) st <= S_STOP;
            else          idx <= idx + IW'(1);
          end
        end
        S_STOP:
          if (cnt == CW'(MID + 1)) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_byte   <= '0;
      rx_bit9   <= 1'b0;
      ready     <= 1'b0;
      frame_err <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      if (rd_strobe) ready <= 1'b0;
      if (take) begin
        rx_byte   <= shreg[DW-1:0];
        rx_bit9   <= m9_l & shreg[DW];
        frame_err <= !vote;
        ready     <= 1'b1;
      end else if (load) begin
        overrun <= 1'b1;
      end
      if (!rx_en) begin
        frame_err <= 1'b0;
        overrun   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/uart_addr_rx_chk.sv
module uart_addr_rx_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_en,
  input logic          rd_strobe,
  input logic          ready,
  input logic          overrun,
  input logic          frame_err,
  input logic [DW-1:0] rx_byte,
  input logic          rx_bit9,
  input logic          load,
  input logic          take,
  input logic          m9_l,
  input logic          ad_l
);
  assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !load) |=> !ready);

  assert_keep_old_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !rd_strobe) |=> $stable(rx_byte));

  assert_overrun_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(ready));

  assert_disable_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (!overrun && !frame_err));

  assert_addr_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && m9_l && ad_l) |=> rx_bit9);

  assert_bit9_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !m9_l) |=> !rx_bit9);
endmodule

bind uart_addr_rx uart_addr_rx_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rd_strobe(rd_strobe),
  .ready(ready), .overrun(overrun), .frame_err(frame_err),
  .rx_byte(rx_byte), .rx_bit9(rx_bit9), .load(load), .take(take),
  .m9_l(m9_l), .ad_l(ad_l)
);

// File: tb/uart_addr_rx_tb_top.sv
`timescale 1ns/1ps
module uart_addr_rx_tb_top;
  localparam int TDIV = 4;

  logic clk = 0, rst_n = 0, rx_en = 0, mode9 = 0, addr_det = 0;
  logic tick = 0, rx_in = 1, rd_strobe = 0;
  logic [7:0] rx_byte;
  logic rx_bit9, ready, frame_err, overrun;
  int divc = 0, n_run = 0, n_fail = 0;
  logic done = 0;

  always #10 clk = ~clk;

  always @(negedge clk) begin
    divc <= (divc == TDIV - 1) ? 0 : divc + 1;
    tick <= (divc == TDIV - 1);
  end

  uart_addr_rx dut_i (.clk(clk), .rst_n(rst_n), .rx_en(rx_en), .mode9(mode9),
    .addr_det(addr_det), .tick(tick), .rx_in(rx_in), .rd_strobe(rd_strobe),
    .rx_byte(rx_byte), .rx_bit9(rx_bit9), .ready(ready),
    .frame_err(frame_err), .overrun(overrun));

  // {mode9, addr_det, stop, expect_delivery, data[8:0]}
  localparam logic [12:0] VEC [8] = '{
    {1'b0, 1'b0, 1'b1, 1'b1, 9'h0A5},
    {1'b0, 1'b1, 1'b1, 1'b1, 9'h03C},
    {1'b1, 1'b0, 1'b1, 1'b1, 9'h155},
    {1'b1, 1'b0, 1'b1, 1'b1, 9'h0F0},
    {1'b1, 1'b1, 1'b1, 1'b0, 9'h0E1},
    {1'b1, 1'b1, 1'b1, 1'b1, 9'h1C3},
    {1'b0, 1'b0, 1'b0, 1'b1, 9'h081},
    {1'b1, 1'b1, 1'b1, 1'b0, 9'h07E}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_tick();
    do @(posedge clk); while (!tick);
    #1;
  endtask

  task automatic do_read();
    @(negedge clk) rd_strobe = 1;
    @(negedge clk) rd_strobe = 0;
  endtask

  task automatic send(input logic m9, input logic [8:0] d, input logic stop,
                      input int gbit, input logic [15:0] gmask, input int flip_at);
    logic [10:0] fr;
    int nb;
    nb = m9 ? 9 : 8;
    fr = '0;
    for (int i = 0; i < nb; i++) fr[i+1] = d[i];
    fr[nb+1] = stop;
    wait_tick();
    for (int p = 0; p <= nb + 1; p++) begin
      if (p == flip_at) addr_det = !addr_det;
      for (int s = 1; s <= 16; s++) begin
        rx_in = fr[p] ^ ((p == gbit) && gmask[s-1]);
        wait_tick();
      end
    end
    rx_in = 1;
    repeat (4) wait_tick();
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] last_b;
    logic last_9;
    last_b = 8'h00;
    last_9 = 1'b0;
    repeat (3) @(negedge clk);
    check("reset ready", ready, 0);
    check("reset overrun", overrun, 0);
    check("reset frame_err", frame_err, 0);
    rst_n = 1;
    rx_en = 1;
    repeat (8) @(negedge clk);

    for (int v = 0; v < 8; v++) begin
      mode9 = VEC[v][12];
      addr_det = VEC[v][11];
      send(VEC[v][12], VEC[v][8:0], VEC[v][10], -1, 16'h0, -1);
      if (VEC[v][9]) begin
        last_b = VEC[v][7:0];
        last_9 = VEC[v][12] & VEC[v][8];
        check("R3/R4/R5 ready", ready, 1);
        check("R2/R3 byte", rx_byte, last_b);
        check("R4 bit9", rx_bit9, last_9);
        check("R6 frame_err", frame_err, !VEC[v][10]);
        do_read();
        @(negedge clk);
        check("R8 ready cleared", ready, 0);
      end else begin
        check("R5 dropped ready", ready, 0);
        check("R5 dropped byte", rx_byte, last_b);
        check("R5 dropped bit9", rx_bit9, last_9);
      end
    end

    mode9 = 0;
    addr_det = 0;
    wait_tick();
    rx_in = 0;
    repeat (4) wait_tick();
    rx_in = 1;
    repeat (30) wait_tick();
    @(negedge clk);
    check("R1 false start", ready, 0);

    send(0, 9'h0A5, 1, 3, 16'h0040, -1);
    check("R2 single glitch sample 7", rx_byte, 8'hA5);
    do_read();
    send(0, 9'h0A5, 1, 3, 16'h0180, -1);
    check("R2 two-sample glitch", rx_byte, 8'hA1);
    do_read();

    send(0, 9'h011, 1, -1, 16'h0, -1);
    send(0, 9'h022, 0, -1, 16'h0, -1);
    check("R7 overrun set", overrun, 1);
    check("R7 old byte kept", rx_byte, 8'h11);
    do_read();
    send(0, 9'h033, 0, -1, 16'h0, -1);
    check("R6 frame_err on delivery", frame_err, 1);
    do_read();
    @(negedge clk) rx_en = 0;
    @(negedge clk);
    @(negedge clk);
    check("R9 overrun cleared", overrun, 0);
    check("R9 frame_err cleared", frame_err, 0);
    send(0, 9'h044, 1, -1, 16'h0, -1);
    check("R9 disabled line ignored", ready, 0);
    rx_en = 1;
    repeat (4) @(negedge clk);

    mode9 = 1;
    addr_det = 1;
    send(1, 9'h05A, 1, -1, 16'h0, 3);
    check("R10 filter held after clear", ready, 0);
    addr_det = 0;
    send(1, 9'h06B, 1, -1, 16'h0, 3);
    check("R10 delivered despite set", ready, 1);
    check("R10 byte", rx_byte, 8'h6B);
    do_read();
    addr_det = 0;
    send(1, 9'h07C, 1, -1, 16'h0, -1);
    check("R5 filter off data delivered", rx_byte, 8'h7C);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule